// File: doc/BRIEF.md
# Periodic Pulse Interrupt Generator

This block raises a sticky pulse flag at a regular interval that software picks. The interval comes from a 100 Hz timebase strobe. Software sets an enable bit, a four-bit select field in which exactly one bit names the interval, and a mask bit. Software acknowledges each event by strobing a flag-clear input. The block also merges its own flag with the flags of the chip's other interrupt sources into one active-low interrupt request. That request is asserted while any flag is set and has its mask bit set.

While the standby input is high the interval counter is held, so no new pulse events occur. The pulse flag and any source not listed as standby-capable are kept away from the interrupt output. When standby drops, the generator picks up again if it is still enabled. It then counts a full interval from that point. Changing the select field also starts a full interval again. This keeps the first event after a reconfiguration a whole period away.

Top module: `tick_irq_gen`

## Requirements
- R1: After a synchronous reset, `pulse_flag` is 0 and `irq_n` is 1.
- R2: The select encoding is bit 0 = every tick (10 ms), bit 1 = every 10 ticks (100 ms), bit 2 = every 100 ticks (1 s), bit 3 = every 6000 ticks (1 min). The flag is set by the tick that completes the interval and reads 1 from the next clock edge on.
- R3: If `ivl_sel` has zero bits set or more than one bit set, no pulse event occurs.
- R4: While `pulse_en` is 0, no pulse event occurs.
- R5: `pulse_flag` stays set until `flag_clr` is strobed. If a pulse event and `flag_clr` fall in the same cycle, the flag ends up set.
- R6: The pulse flag pulls `irq_n` low only while `pulse_mask` is 1. With the mask at 0, `irq_n` stays high even though the flag is set.
- R7: `irq_n` is low whenever any bit of `ext_flags` is set together with the same bit of `ext_masks`.
- R8: While `standby` is 1, no pulse event occurs, and neither the pulse flag nor external source 1 drives `irq_n`. External source 0 (the standby-capable source) still drives `irq_n`.
- R9: When `standby` falls with the generator still enabled, the first event comes one full interval of ticks after the exit.
- R10: When `ivl_sel` changes, the count starts again. The first event under the new selection arrives one full new interval after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_100hz | input | 1 | One-cycle strobe at 100 Hz |
| pulse_en | input | 1 | Pulse generator enable |
| ivl_sel | input | 4 | One-hot interval select |
| pulse_mask | input | 1 | Lets the pulse flag drive the interrupt |
| flag_clr | input | 1 | One-cycle software acknowledge of the pulse flag |
| standby | input | 1 | Standby state indicator |
| ext_flags | input | N_EXT | Flags of the other interrupt sources |
| ext_masks | input | N_EXT | Mask bits of the other interrupt sources |
| pulse_flag | output | 1 | Sticky pulse event flag |
| irq_n | output | 1 | Active-low combined interrupt request |

## Verification
The assertions assume that `tick_100hz` is a single-cycle strobe and that `flag_clr` is a single-cycle acknowledge. They also assume that control inputs change only between clock edges, so a selection change is seen in exactly one cycle. The bench drives every tick as a one-cycle strobe with an idle cycle after it, and it changes the controls only on falling edges. It reconfigures with the enable dropped for a cycle, so that each measured interval starts from a cleared counter.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;

    localparam int NUM_IVL = 4;

    typedef enum logic [1:0] {
        IVL_FAST  = 2'd0,
        IVL_TENTH = 2'd1,
        IVL_SEC   = 2'd2,
        IVL_MIN   = 2'd3
    } ivl_e;

    typedef struct packed {
        logic       en;
        logic [3:0] sel;
        logic       standby;
    } pulse_ctl_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic logic sel_ok(input logic [3:0] s);
        return (s != 4'd0) && ((s & (s - 4'd1)) == 4'd0);
    endfunction

    function automatic ivl_e sel_code(input logic [3:0] s);
        ivl_e r;
        r = IVL_FAST;
        if (s[1]) r = IVL_TENTH;
        if (s[2]) r = IVL_SEC;
        if (s[3]) r = IVL_MIN;
        return r;
    endfunction

endpackage

// File: rtl/tick_ivl_div.sv
module tick_ivl_div
    import tick_irq_pkg::*;
#(
    parameter int DIV0 = 1,
    parameter int DIV1 = 10,
    parameter int DIV2 = 100,
    parameter int DIV3 = 6000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  pulse_ctl_t ctl,
    output logic       fire
);
    localparam int DMAX = max4(DIV0, DIV1, DIV2, DIV3);
    localparam int CW   = (DMAX > 1) ? $clog2(DMAX) : 1;
    localparam int DIV_TAB [NUM_IVL] = '{DIV0, DIV1, DIV2, DIV3};

    logic [CW-1:0] lim_tab [NUM_IVL];
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic [3:0]    sel_q;
    logic          active;
    logic          restart;
    logic          at_end;

    for (genvar g = 0; g < NUM_IVL; g++) begin : g_lim
        assign lim_tab[g] = CW'(DIV_TAB[g] - 1);
    end

    assign active  = ctl.en && sel_ok(ctl.sel) && !ctl.standby;
    assign restart = !active || (ctl.sel != sel_q);
    assign lim     = lim_tab[sel_code(ctl.sel)];
    assign at_end  = (cnt == lim);
    assign fire    = tick && !restart && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            cnt   <= '0;
        end else begin
            sel_q <= ctl.sel;
            if (restart)
                cnt <= '0;
            else if (tick)
                cnt <= at_end ? '0 : cnt + 1'b1;
        end
    end

    // R2: the running count never passes the selected limit
    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        !restart |-> (cnt <= lim));

    // R10: a restart leaves the count at zero
    p_restart_zero_r10: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

    // R3: no event in the cycle after an invalid selection
    p_bad_sel_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !sel_ok(ctl.sel) |=> (cnt == '0));

endmodule

// File: rtl/tick_pulse_flag.sv
module tick_pulse_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    // R5: a pulse event always leaves the flag set, even against a clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

    // R5: a clear with no event drops the flag
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);

    // R5: without set or clear the flag holds its value
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr && !set) |=> $stable(flag));

endmodule

// File: rtl/tick_irq_merge.sv
module tick_irq_merge #(
    parameter int                 N_EXT     = 2,
    parameter logic [N_EXT-1:0]   STBY_KEEP = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse_flag,
    input  logic             pulse_mask,
    input  logic             standby,
    input  logic [N_EXT-1:0] ext_flags,
    input  logic [N_EXT-1:0] ext_masks,
    output logic             irq_n
);
    localparam int NSRC = N_EXT + 1;

    logic [N_EXT-1:0] ext_gate;
    logic [NSRC-1:0]  live;

    assign ext_gate = standby ? STBY_KEEP : {N_EXT{1'b1}};
    assign live     = {ext_flags & ext_masks & ext_gate,
                       pulse_flag & pulse_mask & !standby};
    assign irq_n    = ~(|live);

    // R8: in standby only the standby-capable sources may assert the request
    p_stby_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (standby && ((ext_flags & ext_masks & STBY_KEEP) == '0)) |-> irq_n);

    // R6: an unmasked pulse flag outside standby asserts the request
    p_pulse_drives_r6: assert property (@(posedge clk) disable iff (rst)
        (pulse_flag && pulse_mask && !standby) |-> !irq_n);

    // R7: any unmasked external flag outside standby asserts the request
    p_ext_drives_r7: assert property (@(posedge clk) disable iff (rst)
        (!standby && ((ext_flags & ext_masks) != '0)) |-> !irq_n);

endmodule

// File: rtl/tick_irq_gen.sv
module tick_irq_gen
    import tick_irq_pkg::*;
#(
    parameter int               DIV_FAST  = 1,
    parameter int               DIV_TENTH = 10,
    parameter int               DIV_SEC   = 100,
    parameter int               DIV_MIN   = 6000,
    parameter int               N_EXT     = 2,
    parameter logic [N_EXT-1:0] STBY_KEEP = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_100hz,
    input  logic             pulse_en,
    input  logic [3:0]       ivl_sel,
    input  logic             pulse_mask,
    input  logic             flag_clr,
    input  logic             standby,
    input  logic [N_EXT-1:0] ext_flags,
    input  logic [N_EXT-1:0] ext_masks,
    output logic             pulse_flag,
    output logic             irq_n
);
    pulse_ctl_t ctl;
    logic       fire;

    assign ctl = '{en: pulse_en, sel: ivl_sel, standby: standby};

    tick_ivl_div #(
        .DIV0(DIV_FAST), .DIV1(DIV_TENTH), .DIV2(DIV_SEC), .DIV3(DIV_MIN)
    ) u_div (
        .clk (clk),
        .rst (rst),
        .tick(tick_100hz),
        .ctl (ctl),
        .fire(fire)
    );

    tick_pulse_flag u_flag (
        .clk (clk),
        .rst (rst),
        .set (fire),
        .clr (flag_clr),
        .flag(pulse_flag)
    );

    tick_irq_merge #(
        .N_EXT(N_EXT), .STBY_KEEP(STBY_KEEP)
    ) u_merge (
        .clk       (clk),
        .rst       (rst),
        .pulse_flag(pulse_flag),
        .pulse_mask(pulse_mask),
        .standby   (standby),
        .ext_flags (ext_flags),
        .ext_masks (ext_masks),
        .irq_n     (irq_n)
    );

    // R8: the pulse flag never rises out of a standby cycle
    p_no_rise_in_stby_r8: assert property (@(posedge clk) disable iff (rst)
        standby |=> !$rose(pulse_flag));

    // R4: with the generator disabled the flag cannot rise
    p_no_rise_disabled_r4: assert property (@(posedge clk) disable iff (rst)
        !pulse_en |=> !$rose(pulse_flag));

endmodule

// File: tb/tick_irq_gen_test.sv
`timescale 1ns/1ps
module tick_irq_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_100hz = 1'b0;
    logic       pulse_en = 1'b0;
    logic [3:0] ivl_sel = 4'b0000;
    logic       pulse_mask = 1'b0;
    logic       flag_clr = 1'b0;
    logic       standby = 1'b0;
    logic [1:0] ext_flags = 2'b00;
    logic [1:0] ext_masks = 2'b00;
    logic       pulse_flag;
    logic       irq_n;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tick_irq_gen uut (
        .clk(clk), .rst(rst), .tick_100hz(tick_100hz), .pulse_en(pulse_en),
        .ivl_sel(ivl_sel), .pulse_mask(pulse_mask), .flag_clr(flag_clr),
        .standby(standby), .ext_flags(ext_flags), .ext_masks(ext_masks),
        .pulse_flag(pulse_flag), .irq_n(irq_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick_100hz = 1'b1;
        @(negedge clk) tick_100hz = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    task automatic clr_flag();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    task automatic configure(input logic en, input logic [3:0] sel);
        @(negedge clk) pulse_en = 1'b0;
        @(negedge clk) begin pulse_en = en; ivl_sel = sel; end
        @(negedge clk);
        clr_flag();
    endtask

    task automatic count_ticks(input int limit, output int n);
        n = 0;
        while (!pulse_flag && n < limit) begin
            do_tick();
            n++;
        end
        if (!pulse_flag) n = -1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(pulse_flag == 1'b0, "R1 flag after reset", pulse_flag, 0);
        check(irq_n == 1'b1, "R1 irq_n after reset", irq_n, 1);
    endtask

    task automatic t_intervals();
        int n;
        configure(1'b1, 4'b0001);
        count_ticks(20, n);
        check(n == 1, "R2 bit0 interval", n, 1);
        configure(1'b1, 4'b0010);
        count_ticks(50, n);
        check(n == 10, "R2 bit1 interval", n, 10);
        configure(1'b1, 4'b0100);
        count_ticks(500, n);
        check(n == 100, "R2 bit2 interval", n, 100);
        configure(1'b1, 4'b1000);
        count_ticks(7000, n);
        check(n == 6000, "R2 bit3 interval", n, 6000);
        clr_flag();
        count_ticks(7000, n);
        check(n == 6000, "R2 bit3 second interval", n, 6000);
    endtask

    task automatic t_bad_select();
        configure(1'b1, 4'b0011);
        ticks(30);
        check(pulse_flag == 1'b0, "R3 two select bits", pulse_flag, 0);
        configure(1'b1, 4'b0000);
        ticks(30);
        check(pulse_flag == 1'b0, "R3 no select bit", pulse_flag, 0);
    endtask

    task automatic t_disable();
        configure(1'b0, 4'b0001);
        ticks(20);
        check(pulse_flag == 1'b0, "R4 disabled", pulse_flag, 0);
    endtask

    task automatic t_sticky();
        configure(1'b1, 4'b0001);
        do_tick();
        @(negedge clk) pulse_en = 1'b0;
        repeat (6) @(negedge clk);
        check(pulse_flag == 1'b1, "R5 flag holds", pulse_flag, 1);
        clr_flag();
        check(pulse_flag == 1'b0, "R5 flag cleared", pulse_flag, 0);
        configure(1'b1, 4'b0001);
        @(negedge clk) begin tick_100hz = 1'b1; flag_clr = 1'b1; end
        @(negedge clk) begin tick_100hz = 1'b0; flag_clr = 1'b0; end
        check(pulse_flag == 1'b1, "R5 set beats clear", pulse_flag, 1);
        @(negedge clk) pulse_en = 1'b0;
        clr_flag();
    endtask

    task automatic t_mask();
        configure(1'b1, 4'b0001);
        do_tick();
        @(negedge clk) begin pulse_en = 1'b0; pulse_mask = 1'b0; end
        #1 check(irq_n == 1'b1, "R6 masked flag", irq_n, 1);
        @(negedge clk) pulse_mask = 1'b1;
        #1 check(irq_n == 1'b0, "R6 unmasked flag", irq_n, 0);
        clr_flag();
        #1 check(irq_n == 1'b1, "R6 after clear", irq_n, 1);
        @(negedge clk) pulse_mask = 1'b0;
    endtask

    task automatic t_ext();
        @(negedge clk) begin ext_flags = 2'b01; ext_masks = 2'b00; end
        #1 check(irq_n == 1'b1, "R7 ext masked", irq_n, 1);
        @(negedge clk) ext_masks = 2'b01;
        #1 check(irq_n == 1'b0, "R7 ext0 active", irq_n, 0);
        @(negedge clk) begin ext_flags = 2'b10; ext_masks = 2'b10; end
        #1 check(irq_n == 1'b0, "R7 ext1 active", irq_n, 0);
        @(negedge clk) begin ext_flags = 2'b10; ext_masks = 2'b01; end
        #1 check(irq_n == 1'b1, "R7 mismatched mask", irq_n, 1);
        @(negedge clk) begin ext_flags = 2'b00; ext_masks = 2'b00; end
    endtask

    task automatic t_standby();
        configure(1'b1, 4'b0001);
        @(negedge clk) standby = 1'b1;
        ticks(10);
        check(pulse_flag == 1'b0, "R8 no event in standby", pulse_flag, 0);
        @(negedge clk) standby = 1'b0;
        do_tick();
        @(negedge clk) begin pulse_en = 1'b0; pulse_mask = 1'b1; standby = 1'b1; end
        #1 check(irq_n == 1'b1, "R8 pulse blocked in standby", irq_n, 1);
        @(negedge clk) begin ext_flags = 2'b10; ext_masks = 2'b11; end
        #1 check(irq_n == 1'b1, "R8 ext1 blocked in standby", irq_n, 1);
        @(negedge clk) ext_flags = 2'b01;
        #1 check(irq_n == 1'b0, "R8 ext0 kept in standby", irq_n, 0);
        @(negedge clk) begin ext_flags = 2'b00; ext_masks = 2'b00;
                             standby = 1'b0; pulse_mask = 1'b0; end
        clr_flag();
    endtask

    task automatic t_resume();
        int n;
        configure(1'b1, 4'b0010);
        ticks(6);
        @(negedge clk) standby = 1'b1;
        ticks(30);
        check(pulse_flag == 1'b0, "R8 held during standby", pulse_flag, 0);
        @(negedge clk) standby = 1'b0;
        count_ticks(50, n);
        check(n == 10, "R9 full interval after standby", n, 10);
    endtask

    task automatic t_reselect();
        int n;
        configure(1'b1, 4'b0100);
        ticks(60);
        check(pulse_flag == 1'b0, "R10 before change", pulse_flag, 0);
        @(negedge clk) ivl_sel = 4'b0010;
        count_ticks(50, n);
        check(n == 10, "R10 new 100ms interval", n, 10);
        configure(1'b1, 4'b0010);
        ticks(5);
        @(negedge clk) ivl_sel = 4'b0100;
        count_ticks(500, n);
        check(n == 100, "R10 new 1s interval", n, 100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_intervals();
        t_bad_select();
        t_disable();
        t_sticky();
        t_mask();
        t_ext();
        t_standby();
        t_resume();
        t_reselect();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule